// File: doc/BRIEF.md
# Burst-Segmenting Packet Transmit Framer

The framer collects packets from up to ten per-port packet sources and turns them into a single stream of 16-bit words with a flag that separates control words from data words. A transfer opens with a payload control word that names the port and says whether a new packet starts. Data words for that port then follow back to back. The transfer closes when the packet ends or when the programmed burst size has been sent. Every cycle that carries no transfer carries an idle control word.

The end of a packet is not signalled in the data. The next control word carries it, whether that word is an idle or the payload control word that opens the next transfer. Arbitration is round robin over the ports that hold credit and have work. A port whose packet was cut at the burst limit resumes it later with a continuation control word that has the start flag clear. Start-of-packet control words are kept at least eight word cycles apart, and idles fill any shortfall. When padding is enabled, frames shorter than 64 bytes are stretched with zero words.

Top module: `burst_framer`

## Requirements
- R1: While reset is asserted, and on the first output cycle after reset, `tx_ctl` is 1, `tx_word` is the idle word 16'h0000 and no `src_pop` bit is set.
- R2: Control words have a fixed layout: bit 15 = 1 for a payload control word and 0 for an idle; bit 14 = end of packet for the burst just before; bit 13 = start of packet; bits 11:8 = port number. Every other bit is 0. An idle word always has bits 13 and 11:8 at 0.
- R3: The cycle that follows a payload control word always carries a data word (`tx_ctl` = 0).
- R4: A data word never follows an idle control word. Within a burst, data words come from the addressed port in source order with no gaps. At most one `src_pop` bit is set in any cycle.
- R5: A burst ends only after exactly `max_burst`×8 data words, or on the last word of a packet. It is never longer than `max_burst`×8 words. `max_burst` counts 16-byte units and must be nonzero.
- R6: Bit 14 is set on the first control word after the burst that carried a packet's final word, and on no other control word.
- R7: Two start-of-packet control words are at least eight word cycles apart.
- R8: A packet cut at the burst limit resumes on the same port with a payload control word whose bit 13 is 0. Its data continues from the next unsent word.
- R9: A payload control word for port p is sent only if `credit[p]` was high in the cycle before it. Dropping credit during a burst does not shorten that burst.
- R10: With `pad_en` = 1, a packet of fewer than 32 words is followed by zero-valued data words until it is 32 words long, and bit 14 follows the last pad word. With `pad_en` = 0, short packets pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| src_data | input | NPORT*16 | Head word of each port's source, port p at bits [16p+15:16p] |
| src_valid | input | NPORT | Source p has a head word |
| src_sop | input | NPORT | Head word of source p is the first of a packet |
| src_eop | input | NPORT | Head word of source p is the last of a packet |
| src_pop | output | NPORT | Source p head word consumed at this clock edge |
| credit | input | NPORT | Port p may receive a new burst |
| max_burst | input | MB_W | Burst limit in 16-byte (8-word) units, nonzero |
| pad_en | input | 1 | Pad packets shorter than 32 words with zero words |
| tx_word | output | 16 | Outgoing word |
| tx_ctl | output | 1 | 1 = `tx_word` is a control word, 0 = data word |

## Verification
The framer's state is visible in its output almost at once. A burst counter that is wrong shows within one word as a control word at a non-multiple of eight, or as a burst that runs past the limit. A stale per-port continuation flag shows on the next control word for that port as a wrong start bit. A lost pending end-of-packet shows on the very next control word. A fault in the start-spacing counter shows as a start word fewer than eight cycles after the previous one. A fault in the padding count shows as a zero word out of place, or as a packet whose end flag arrives at the wrong length. Any of these is visible in the first word that depends on the faulty state.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
  localparam int WORD_W = 16;
  localparam int PORT_W = 4;
  localparam int CW_PAY  = 15;
  localparam int CW_EOP  = 14;
  localparam int CW_SOP  = 13;
  localparam int CW_PORT = 8;

  typedef enum logic {S_GAP = 1'b0, S_BURST = 1'b1} bfr_state_e;

  function automatic logic [WORD_W-1:0] ctl_word(input logic pay, input logic eop,
                                                 input logic sop, input logic [PORT_W-1:0] port);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CW_PAY] = pay;
    w[CW_EOP] = eop;
    w[CW_SOP] = sop;
    w[CW_PORT +: PORT_W] = port;
    return w;
  endfunction
endpackage

// File: rtl/bfr_rr_arb.sv
module bfr_rr_arb #(
  parameter int N  = 10,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 1; i <= N; i++) begin
      if (!gnt_valid && req[(int'(last_q) + i) % N]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'((int'(last_q) + i) % N);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (take) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/bfr_sop_spacer.sv
module bfr_sop_spacer #(
  parameter int GAP = 8,
  parameter int CW  = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ok
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)                    cnt_d = CW'(1);
    else if (cnt_q != CW'(GAP))  cnt_d = cnt_q + CW'(1);
  end

  assign ok = (cnt_q == CW'(GAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(GAP);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/burst_framer.sv
module burst_framer
  import bfr_pkg::*;
#(
  parameter int NPORT     = 10,
  parameter int MB_W      = 4,
  parameter int MIN_WORDS = 32,
  parameter int SOP_GAP   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT*WORD_W-1:0]   src_data,
  input  logic [NPORT-1:0]          src_valid,
  input  logic [NPORT-1:0]          src_sop,
  input  logic [NPORT-1:0]          src_eop,
  output logic [NPORT-1:0]          src_pop,
  input  logic [NPORT-1:0]          credit,
  input  logic [MB_W-1:0]           max_burst,
  input  logic                      pad_en,
  output logic [WORD_W-1:0]         tx_word,
  output logic                      tx_ctl
);
  localparam int IW  = $clog2(NPORT);
  localparam int BCW = MB_W + 3;
  localparam int PCW = $clog2(MIN_WORDS + 1);

  bfr_state_e        state_q, state_d;
  logic [IW-1:0]     cur_q, cur_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic              eop_q, eop_d;
  logic [NPORT-1:0]  mid_q, pad_q;
  logic [PCW-1:0]    pcnt_q [NPORT];
  logic [WORD_W-1:0] word_q, word_d;
  logic              ctl_q, ctl_d;

  logic [NPORT-1:0]  req;
  logic              gnt_valid, take, sop_fire, gap_ok;
  logic [IW-1:0]     gnt_idx;
  logic [WORD_W-1:0] cur_word;
  logic              cur_pad, src_last, pkt_end, start_pad, burst_full;
  logic [PCW-1:0]    cnt_n;
  logic [BCW-1:0]    burst_lim;

  // eligibility: continuing packets need data or padding, new packets need spacing
  for (genvar p = 0; p < NPORT; p++) begin : g_req
    assign req[p] = credit[p] & (mid_q[p] ? (pad_q[p] | src_valid[p])
                                          : (src_valid[p] & src_sop[p] & gap_ok));
  end

  bfr_rr_arb #(.N(NPORT), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .take(take),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  bfr_sop_spacer #(.GAP(SOP_GAP)) u_gap (
    .clk(clk), .rst_n(rst_n), .fire(sop_fire), .ok(gap_ok)
  );

  // per-word burst bookkeeping for the port being served
  assign burst_lim  = {max_burst, 3'b000};
  assign cur_word   = src_data[int'(cur_q)*WORD_W +: WORD_W];
  assign cur_pad    = pad_q[cur_q];
  assign cnt_n      = (pcnt_q[cur_q] >= PCW'(MIN_WORDS)) ? PCW'(MIN_WORDS)
                                                         : pcnt_q[cur_q] + PCW'(1);
  assign src_last   = !cur_pad && src_eop[cur_q];
  assign pkt_end    = cur_pad ? (cnt_n == PCW'(MIN_WORDS))
                              : (src_last && (!pad_en || cnt_n == PCW'(MIN_WORDS)));
  assign start_pad  = src_last && pad_en && (cnt_n != PCW'(MIN_WORDS));
  assign burst_full = ((bcnt_q + BCW'(1)) == burst_lim);
  assign take       = (state_q == S_GAP) && gnt_valid;
  assign sop_fire   = take && !mid_q[gnt_idx];

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    bcnt_d  = bcnt_q;
    eop_d   = eop_q;
    word_d  = ctl_word(1'b0, 1'b0, 1'b0, '0);
    ctl_d   = 1'b1;
    src_pop = '0;
    if (state_q == S_GAP) begin
      eop_d = 1'b0;
      if (gnt_valid) begin
        word_d  = ctl_word(1'b1, eop_q, !mid_q[gnt_idx], PORT_W'(gnt_idx));
        cur_d   = gnt_idx;
        bcnt_d  = '0;
        state_d = S_BURST;
      end else begin
        word_d  = ctl_word(1'b0, eop_q, 1'b0, '0);
      end
    end else begin
      ctl_d          = 1'b0;
      word_d         = cur_pad ? '0 : cur_word;
      src_pop[cur_q] = !cur_pad;
      if (pkt_end || burst_full) begin
        state_d = S_GAP;
        bcnt_d  = '0;
        eop_d   = pkt_end;
      end else begin
        bcnt_d  = bcnt_q + BCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_GAP;
      cur_q   <= '0;
      bcnt_q  <= '0;
      eop_q   <= 1'b0;
      mid_q   <= '0;
      pad_q   <= '0;
      for (int i = 0; i < NPORT; i++) pcnt_q[i] <= '0;
      word_q  <= '0;
      ctl_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      bcnt_q  <= bcnt_d;
      eop_q   <= eop_d;
      word_q  <= word_d;
      ctl_q   <= ctl_d;
      if (take) mid_q[gnt_idx] <= 1'b1;
      if (state_q == S_BURST) begin
        mid_q[cur_q]  <= !pkt_end;
        pad_q[cur_q]  <= !pkt_end && (cur_pad || start_pad);
        pcnt_q[cur_q] <= pkt_end ? '0 : cnt_n;
      end
    end
  end

  assign tx_word = word_q;
  assign tx_ctl  = ctl_q;
endmodule

// File: rtl/bfr_checker.sv
module bfr_checker #(
  parameter int NPORT = 10,
  parameter int MB_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] credit,
  input logic [MB_W-1:0]  max_burst,
  input logic [NPORT-1:0] src_pop,
  input logic [15:0]      tx_word,
  input logic             tx_ctl
);
  localparam logic [1:0] K_IDLE = 2'd0, K_PAY = 2'd1, K_DATA = 2'd2;

  logic [1:0]      prev_kind;
  logic [MB_W+2:0] run;
  logic [3:0]      gap;
  logic [15:0]     cred_q;
  logic            is_pay, is_sop;

  assign is_pay = tx_ctl && tx_word[15];
  assign is_sop = is_pay && tx_word[13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_kind <= K_IDLE;
      run       <= '0;
      gap       <= 4'd8;
      cred_q    <= '0;
    end else begin
      prev_kind <= !tx_ctl ? K_DATA : (is_pay ? K_PAY : K_IDLE);
      run       <= tx_ctl ? '0 : run + 1'b1;
      gap       <= is_sop ? 4'd1 : ((gap == 4'd8) ? gap : gap + 4'd1);
      cred_q    <= 16'(credit);
    end
  end

  AST_PAYLOAD_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_kind == K_PAY) |-> !tx_ctl);                                    // R3
  AST_NO_DATA_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_kind == K_IDLE) |-> tx_ctl);                                    // R4
  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_pop));                                                   // R4
  AST_BURST_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_kind == K_DATA && tx_ctl) |-> (tx_word[14] || run == {max_burst, 3'b000})); // R5
  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ctl |-> (run < {max_burst, 3'b000}));                             // R5
  AST_BURST_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    max_burst != '0);                                                     // R5
  AST_SOP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    is_sop |-> (gap >= 4'd8));                                            // R7
  AST_CREDIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    is_pay |-> cred_q[tx_word[11:8]]);                                    // R9
endmodule

bind burst_framer bfr_checker #(.NPORT(NPORT), .MB_W(MB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .credit(credit), .max_burst(max_burst),
  .src_pop(src_pop), .tx_word(tx_word), .tx_ctl(tx_ctl)
);

// File: tb/burst_framer_test.sv
module burst_framer_test;
  localparam int NPORT = 10;
  localparam int MB_W  = 4;
  localparam int DEPTH = 256;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NPORT*16-1:0]   src_data;
  logic [NPORT-1:0]      src_valid, src_sop, src_eop, src_pop;
  logic [NPORT-1:0]      credit = '1;
  logic [MB_W-1:0]       max_burst = 4'd1;
  logic                  pad_en = 1'b0;
  logic [15:0]           tx_word;
  logic                  tx_ctl;

  burst_framer #(.NPORT(NPORT), .MB_W(MB_W)) uut (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_valid(src_valid),
    .src_sop(src_sop), .src_eop(src_eop), .src_pop(src_pop), .credit(credit),
    .max_burst(max_burst), .pad_en(pad_en), .tx_word(tx_word), .tx_ctl(tx_ctl)
  );

  always #5 clk = ~clk;

  // source queues and expected output streams
  logic [15:0] sw [NPORT][DEPTH];
  logic        ss [NPORT][DEPTH];
  logic        se [NPORT][DEPTH];
  logic [15:0] ew [NPORT][DEPTH];
  logic        el [NPORT][DEPTH];
  int sn [NPORT];
  int hd [NPORT];
  int en [NPORT];
  int eidx [NPORT];
  logic mid_m [NPORT];
  int seq = 1;
  int vectors = 0, miscompares = 0;
  logic done = 1'b0;

  initial begin
    for (int p = 0; p < NPORT; p++) begin
      sn[p] = 0; hd[p] = 0; en[p] = 0; eidx[p] = 0; mid_m[p] = 1'b0;
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      src_valid[p] = hd[p] < sn[p];
      src_data[p*16 +: 16] = src_valid[p] ? sw[p][hd[p]] : 16'h0;
      src_sop[p] = src_valid[p] ? ss[p][hd[p]] : 1'b0;
      src_eop[p] = src_valid[p] ? se[p][hd[p]] : 1'b0;
    end
  end

  always @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) if (src_pop[p]) hd[p] <= hd[p] + 1;
  end

  logic [NPORT-1:0] cred_snap;
  logic [MB_W-1:0]  mb_snap;
  always @(posedge clk) begin
    cred_snap <= credit;
    mb_snap   <= max_burst;
  end

  task automatic fail(input string req, input string what, input int act, input int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) fail(req, what, act, exp);
  endtask

  task automatic add_pkt(input int p, input int len);
    int tot;
    tot = (pad_en && len < 32) ? 32 : len;
    for (int i = 0; i < len; i++) begin
      sw[p][sn[p] + i] = {p[3:0], seq[11:0]};
      ss[p][sn[p] + i] = (i == 0);
      se[p][sn[p] + i] = (i == len - 1);
      ew[p][en[p] + i] = {p[3:0], seq[11:0]};
      el[p][en[p] + i] = (i == tot - 1);
      seq++;
    end
    for (int i = len; i < tot; i++) begin
      ew[p][en[p] + i] = 16'h0;
      el[p][en[p] + i] = (i == tot - 1);
    end
    en[p] = en[p] + tot;
    sn[p] = sn[p] + len;
  endtask

  // output stream model, compared every cycle
  int   prev_kind = 0;
  int   cur_p = 0, blen = 0, sop_gap = 100;
  logic eop_exp = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      sop_gap++;
      if (tx_ctl) begin
        if (prev_kind == 1) fail("R3", "control word right after payload", 1, 0);
        if (prev_kind == 2 && !eop_exp && blen != 8 * int'(mb_snap))
          fail("R5", "burst cut length", blen, 8 * int'(mb_snap));
        if (tx_word[15]) begin
          int port;
          port = int'(tx_word[11:8]);
          if (port >= NPORT) fail("R2", "port field", port, NPORT - 1);
          else begin
            if (tx_word != {1'b1, eop_exp, !mid_m[port], 1'b0, tx_word[11:8], 8'h00})
              fail(mid_m[port] ? "R8" : "R2", "payload word", tx_word,
                   {1'b1, eop_exp, !mid_m[port], 1'b0, tx_word[11:8], 8'h00});
            if (!cred_snap[port]) fail("R9", "payload without credit", port, 0);
            if (tx_word[13]) begin
              if (sop_gap < 8) fail("R7", "sop spacing", sop_gap, 8);
              sop_gap = 0;
            end
            mid_m[port] = 1'b1;
            cur_p = port;
          end
          blen = 0;
          prev_kind = 1;
        end else begin
          if (tx_word != {1'b0, eop_exp, 14'h0})
            fail(eop_exp ? "R6" : "R2", "idle word", tx_word, {1'b0, eop_exp, 14'h0});
          prev_kind = 0;
        end
        eop_exp = 1'b0;
      end else begin
        if (prev_kind == 0) fail("R4", "data after idle", 1, 0);
        if (eidx[cur_p] >= en[cur_p]) fail("R4", "unexpected data word", tx_word, 0);
        else begin
          if (tx_word != ew[cur_p][eidx[cur_p]])
            fail(ew[cur_p][eidx[cur_p]] == 16'h0 ? "R10" : "R4", "data word",
                 tx_word, ew[cur_p][eidx[cur_p]]);
          if (el[cur_p][eidx[cur_p]]) begin
            eop_exp = 1'b1;
            mid_m[cur_p] = 1'b0;
          end
          eidx[cur_p] = eidx[cur_p] + 1;
        end
        blen++;
        if (blen > 8 * int'(mb_snap)) fail("R5", "burst too long", blen, 8 * int'(mb_snap));
        prev_kind = 2;
      end
    end
  end

  function automatic bit drained();
    for (int p = 0; p < NPORT; p++) if (eidx[p] != en[p] || hd[p] != sn[p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic wait_drained(input string req);
    int t;
    t = 0;
    while (!drained() && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(t < 4000, req, "all words delivered", t, 0);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_ctl == 1'b1 && tx_word == 16'h0 && src_pop == '0, "R1", "in reset",
          {tx_ctl, tx_word}, 32'h10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ctl == 1'b1 && tx_word == 16'h0 && src_pop == '0, "R1", "after reset",
          {tx_ctl, tx_word}, 32'h10000);

    // long packets cut into 8-word bursts and resumed (R5, R8)
    max_burst = 4'd1; pad_en = 1'b0;
    add_pkt(3, 40);
    add_pkt(0, 20);
    wait_drained("R8");

    // short packets, padding off: start spacing and pass-through (R7, R10)
    max_burst = 4'd2;
    for (int k = 0; k < 4; k++) begin
      add_pkt(1, 2);
      add_pkt(4, 2);
    end
    add_pkt(6, 1);
    wait_drained("R7");

    // padding on, lengths either side of 32 words (R10, R6)
    pad_en = 1'b1; max_burst = 4'd4;
    add_pkt(9, 5);
    add_pkt(2, 31);
    add_pkt(6, 32);
    add_pkt(0, 1);
    wait_drained("R10");
    pad_en = 1'b0;

    // a port without credit is not served (R9)
    credit = '1; credit[7] = 1'b0;
    add_pkt(7, 10);
    add_pkt(5, 12);
    repeat (200) @(negedge clk);
    check(eidx[7] == 0, "R9", "words sent to port without credit", eidx[7], 0);
    check(eidx[5] == 12, "R9", "other port served", eidx[5], 12);
    credit = '1;
    wait_drained("R9");

    // credit dropped during a burst: that burst still completes (R9)
    max_burst = 4'd4;
    add_pkt(8, 70);
    repeat (3) @(negedge clk);
    credit = '0;
    repeat (60) @(negedge clk);
    check(eidx[8] == 32, "R9", "burst length after credit drop", eidx[8], 32);
    credit = '1;
    wait_drained("R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R4 watchdog expired: actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule